// File: doc/BRIEF.md
# Standby Clock Gating Controller

This block manages the two low-power states of a small processor core. Software writes a clock control word. Its two upper bits ask for one of two standby depths: a shallow one that gates only the CPU clock, and a deep one that also stops the main oscillator and clamps its input. The block decides which clock enables stay on while the core sleeps. It wakes the core when an enabled interrupt request arrives, or on reset.

The low field of the control word selects the CPU clock. When a write changes that field, a settling window opens. A standby request made inside that window waits and is applied when the window closes. After a wake from deep standby, the CPU clock stays gated until an oscillator warm-up count has run out. Each peripheral clock enable follows the main oscillator, unless that peripheral has selected a clock source that survives deep standby.

Top module: `stby_clk_ctl`

## Requirements
- R1: A write to `ccr_wdata` with bit 2 set asks for light standby; with bit 3 set it asks for deep standby, and deep standby wins when both bits are set. `stby_status` reads 2'b00 in run, 2'b01 in light standby and 2'b10 in deep standby. Writes are accepted only in run mode.
- R2: In light standby `cpu_clk_en` is 0, `main_osc_en` is 1 and `osc_in_clamp` is 0.
- R3: In deep standby `main_osc_en` is 0, `cpu_clk_en` is 0, and `osc_in_clamp` is 1 for every cycle until a wake.
- R4: A deep standby request applied while `cpu_on_sub` is 1 is discarded with no change of state. A light standby request is accepted whatever the value of `cpu_on_sub`.
- R5: A standby state is left only when some line has both `irq_req[i]` and `irq_en[i]` at 1. A request whose enable is 0 has no effect.
- R6: Leaving light standby makes `cpu_clk_en` 1 on the clock edge that follows the wake cycle.
- R7: On a wake from deep standby, `main_osc_en` rises and `osc_in_clamp` falls on the next edge. `cpu_clk_en` stays 0 for STAB_CYC (16) cycles after that edge, and `stby_status` keeps reading 2'b10 until `cpu_clk_en` rises.
- R8: A write that changes `ccr_wdata[1:0]` opens a window of SETTLE_CYC (4) cycles. A standby request that is pending in that window takes effect exactly SETTLE_CYC cycles later than it would without the window.
- R9: `periph_clk_en[i]` = (oscillator running and `main_osc_on`) OR (`periph_alt_sel[i]` AND the peripheral can use an alternate source). The bit order is [0] interval/watchdog timer, which has no alternate source and ignores `periph_alt_sel[0]`; [1] serial interface with an external clock; [2] event counter with a pin clock; [3] clock timer on the subsystem clock.
- R10: In deep standby `irq_req[0]` is not a wake source unless `int0_bypass` is 1. All other lines, and line 0 in light standby, remain wake sources.
- R11: `ccr_sel` keeps its value across standby entry and exit. Pending standby requests clear themselves on the return to run, so run mode persists with no new write.
- R12: An asynchronous low `rst_n` forces run mode, `ccr_sel` = 0 and no pending request, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ccr_wr | input | 1 | Write strobe for the clock control word |
| ccr_wdata | input | 4 | [1:0] CPU clock select, [2] light standby, [3] deep standby |
| cpu_on_sub | input | 1 | CPU currently runs from the subsystem clock |
| main_osc_on | input | 1 | Main oscillator currently oscillating |
| periph_alt_sel | input | 4 | Per-peripheral alternate clock source selected |
| int0_bypass | input | 1 | Noise filter on interrupt line 0 bypassed |
| irq_req | input | 8 | Interrupt request flags |
| irq_en | input | 8 | Interrupt enable flags |
| cpu_clk_en | output | 1 | CPU clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| osc_in_clamp | output | 1 | Forces the oscillator input to ground |
| periph_clk_en | output | 4 | Per-peripheral clock enables |
| ccr_sel | output | 2 | Stored CPU clock select field |
| stby_status | output | 2 | Current mode code |

## Verification
The bench counts edges around the clock-select settling window. A design that applies the request early, or that drops it, shows the wrong mode one or more cycles off. It counts the warm-up cycles after a deep wake, which catches a CPU clock that is released one cycle early or late, and a clamp that is held into warm-up. It tries a deep request while the CPU runs on the subsystem clock and then clears that condition, which shows a request that was kept instead of discarded. It raises line 0 in deep standby with the filter in place, and raises a line whose enable is off, to catch wakes that should not happen. Peripheral enables are checked against each source selection in both depths.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_HALT = 2'b01,
      ST_STOP = 2'b10,
      ST_WARM = 2'b11
   } stby_state_e;

   localparam logic [1:0] STAT_RUN  = 2'b00;
   localparam logic [1:0] STAT_HALT = 2'b01;
   localparam logic [1:0] STAT_STOP = 2'b10;
endpackage

// File: rtl/stby_settle.sv
module stby_settle #(
   parameter int SEL_W      = 2,
   parameter int SETTLE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] wsel,
   output logic [SEL_W-1:0] sel_q,
   output logic             busy
);
   if (SEL_W < 1) begin : g_bad_w
      $error("stby_settle: SEL_W must be at least 1");
   end
   if (SETTLE_CYC < 0) begin : g_bad_c
      $error("stby_settle: SETTLE_CYC must not be negative");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sel_q <= '0;
      else if (wr) sel_q <= wsel;
   end

   if (SETTLE_CYC == 0) begin : g_nowin
      assign busy = 1'b0;
   end else begin : g_win
      localparam int CW = $clog2(SETTLE_CYC + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      cnt_q <= '0;
         else if (wr && (wsel != sel_q))  cnt_q <= CW'(SETTLE_CYC);
         else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
      end
      assign busy = (cnt_q != '0);
   end

   AST_SEL_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(sel_q)); // R11
endmodule

// File: rtl/stby_wake.sv
module stby_wake #(
   parameter int NIRQ     = 8,
   parameter int INT0_IDX = 0
) (
   input  logic [NIRQ-1:0] irq_req,
   input  logic [NIRQ-1:0] irq_en,
   input  logic            in_stop,
   input  logic            int0_bypass,
   output logic            wake
);
   if (NIRQ < 1) begin : g_bad_n
      $error("stby_wake: NIRQ must be at least 1");
   end
   if (INT0_IDX < 0 || INT0_IDX >= NIRQ) begin : g_bad_i
      $error("stby_wake: INT0_IDX out of range");
   end

   logic [NIRQ-1:0] qual;

   for (genvar i = 0; i < NIRQ; i++) begin : g_line
      if (i == INT0_IDX) begin : g_filt
         assign qual[i] = irq_req[i] & irq_en[i] & (~in_stop | int0_bypass);
      end else begin : g_plain
         assign qual[i] = irq_req[i] & irq_en[i];
      end
   end

   assign wake = |qual;
endmodule

// File: rtl/stby_periph_gate.sv
module stby_periph_gate #(
   parameter int              NPER        = 4,
   parameter logic [NPER-1:0] ALT_CAPABLE = 4'b1110
) (
   input  logic            osc_run,
   input  logic            main_osc_on,
   input  logic [NPER-1:0] alt_sel,
   output logic [NPER-1:0] clk_en
);
   if (NPER < 1) begin : g_bad_n
      $error("stby_periph_gate: NPER must be at least 1");
   end

   logic main_ok;
   assign main_ok = osc_run & main_osc_on;

   for (genvar i = 0; i < NPER; i++) begin : g_per
      if (ALT_CAPABLE[i]) begin : g_alt
         assign clk_en[i] = main_ok | alt_sel[i];
      end else begin : g_main
         assign clk_en[i] = main_ok;
      end
   end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import stby_pkg::*;
#(
   parameter int STAB_CYC = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ok,
   input  logic        req_halt,
   input  logic        req_stop,
   input  logic        busy,
   input  logic        cpu_on_sub,
   input  logic        wake,
   output stby_state_e state_q,
   output logic        cpu_clk_en,
   output logic        osc_en,
   output logic        clamp
);
   if (STAB_CYC < 1) begin : g_bad_s
      $error("stby_fsm: STAB_CYC must be at least 1");
   end

   localparam int SW = $clog2(STAB_CYC + 1);

   stby_state_e state_n;
   logic        ph_q, ph_n, ps_q, ps_n;
   logic [SW-1:0] cnt_q, cnt_n;

   always_comb begin
      state_n = state_q;
      ph_n    = ph_q;
      ps_n    = ps_q;
      cnt_n   = cnt_q;
      unique case (state_q)
         ST_RUN: begin
            if (!busy && (ph_q || ps_q)) begin
               if (ps_q && !cpu_on_sub) begin
                  state_n = ST_STOP;
               end else begin
                  ps_n = 1'b0;
                  if (ph_q) state_n = ST_HALT;
               end
            end
            if (wr_ok) begin
               ph_n = ph_n | req_halt;
               ps_n = ps_n | req_stop;
            end
         end
         ST_HALT: begin
            if (wake) begin
               state_n = ST_RUN;
               ph_n    = 1'b0;
               ps_n    = 1'b0;
            end
         end
         ST_STOP: begin
            if (wake) begin
               state_n = ST_WARM;
               cnt_n   = SW'(STAB_CYC - 1);
            end
         end
         ST_WARM: begin
            if (cnt_q == '0) begin
               state_n = ST_RUN;
               ph_n    = 1'b0;
               ps_n    = 1'b0;
            end else begin
               cnt_n = cnt_q - 1'b1;
            end
         end
         default: state_n = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         ph_q    <= 1'b0;
         ps_q    <= 1'b0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_n;
         ph_q    <= ph_n;
         ps_q    <= ps_n;
         cnt_q   <= cnt_n;
      end
   end

   assign cpu_clk_en = (state_q == ST_RUN);
   assign osc_en     = (state_q != ST_STOP);
   assign clamp      = (state_q == ST_STOP);

   AST_STOP_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp) |-> $past(!cpu_on_sub)); // R4
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP && !wake) |=> clamp); // R3
   AST_HALT_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && !wake) |=> (state_q == ST_HALT)); // R5
   AST_HALT_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && wake) |=> cpu_clk_en); // R6
   AST_WARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WARM && cnt_q != '0) |=> !cpu_clk_en); // R7
   AST_BUSY_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && busy) |=> (state_q == ST_RUN)); // R8
endmodule

// File: rtl/stby_clk_ctl.sv
module stby_clk_ctl
   import stby_pkg::*;
#(
   parameter int              SEL_W       = 2,
   parameter int              NIRQ        = 8,
   parameter int              INT0_IDX    = 0,
   parameter int              NPER        = 4,
   parameter logic [NPER-1:0] ALT_CAPABLE = 4'b1110,
   parameter int              SETTLE_CYC  = 4,
   parameter int              STAB_CYC    = 16,
   localparam int             CCR_W       = SEL_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ccr_wr,
   input  logic [CCR_W-1:0] ccr_wdata,
   input  logic             cpu_on_sub,
   input  logic             main_osc_on,
   input  logic [NPER-1:0]  periph_alt_sel,
   input  logic             int0_bypass,
   input  logic [NIRQ-1:0]  irq_req,
   input  logic [NIRQ-1:0]  irq_en,
   output logic             cpu_clk_en,
   output logic             main_osc_en,
   output logic             osc_in_clamp,
   output logic [NPER-1:0]  periph_clk_en,
   output logic [SEL_W-1:0] ccr_sel,
   output logic [1:0]       stby_status
);
   localparam int HALT_BIT = SEL_W;
   localparam int STOP_BIT = SEL_W + 1;

   stby_state_e state;
   logic        wr_ok, busy, wake;

   assign wr_ok = ccr_wr & (state == ST_RUN);

   stby_settle #(.SEL_W(SEL_W), .SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ok),
      .wsel  (ccr_wdata[SEL_W-1:0]),
      .sel_q (ccr_sel),
      .busy  (busy)
   );

   stby_wake #(.NIRQ(NIRQ), .INT0_IDX(INT0_IDX)) u_wake (
      .irq_req     (irq_req),
      .irq_en      (irq_en),
      .in_stop     (state == ST_STOP),
      .int0_bypass (int0_bypass),
      .wake        (wake)
   );

   stby_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ok      (wr_ok),
      .req_halt   (ccr_wdata[HALT_BIT]),
      .req_stop   (ccr_wdata[STOP_BIT]),
      .busy       (busy),
      .cpu_on_sub (cpu_on_sub),
      .wake       (wake),
      .state_q    (state),
      .cpu_clk_en (cpu_clk_en),
      .osc_en     (main_osc_en),
      .clamp      (osc_in_clamp)
   );

   stby_periph_gate #(.NPER(NPER), .ALT_CAPABLE(ALT_CAPABLE)) u_gate (
      .osc_run     (main_osc_en),
      .main_osc_on (main_osc_on),
      .alt_sel     (periph_alt_sel),
      .clk_en      (periph_clk_en)
   );

   always_comb begin
      unique case (state)
         ST_RUN:  stby_status = STAT_RUN;
         ST_HALT: stby_status = STAT_HALT;
         default: stby_status = STAT_STOP;
      endcase
   end

   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_wr && !cpu_clk_en) |=> $stable(ccr_sel)); // R1
   AST_CLAMP_NO_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      osc_in_clamp |-> (stby_status == STAT_STOP)); // R3
endmodule

// File: tb/stby_clk_ctl_bench.sv
`timescale 1ns/1ps
module stby_clk_ctl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ccr_wr = 1'b0;
   logic [3:0] ccr_wdata = '0;
   logic       cpu_on_sub = 1'b0;
   logic       main_osc_on = 1'b1;
   logic [3:0] periph_alt_sel = '0;
   logic       int0_bypass = 1'b0;
   logic [7:0] irq_req = '0;
   logic [7:0] irq_en = '0;
   logic       cpu_clk_en, main_osc_en, osc_in_clamp;
   logic [3:0] periph_clk_en;
   logic [1:0] ccr_sel, stby_status;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   stby_clk_ctl u_stby_clk_ctl (
      .clk(clk), .rst_n(rst_n), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
      .cpu_on_sub(cpu_on_sub), .main_osc_on(main_osc_on),
      .periph_alt_sel(periph_alt_sel), .int0_bypass(int0_bypass),
      .irq_req(irq_req), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
      .main_osc_en(main_osc_en), .osc_in_clamp(osc_in_clamp),
      .periph_clk_en(periph_clk_en), .ccr_sel(ccr_sel),
      .stby_status(stby_status)
   );

   // {deep, main_osc_on, periph_alt_sel[3:0], expected periph_clk_en[3:0]}
   localparam int NV = 8;
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 1'b1, 4'b0000, 4'b1111},
      {1'b0, 1'b0, 4'b0000, 4'b0000},
      {1'b0, 1'b0, 4'b1010, 4'b1010},
      {1'b1, 1'b1, 4'b0000, 4'b0000},
      {1'b1, 1'b1, 4'b0010, 4'b0010},
      {1'b1, 1'b1, 4'b0100, 4'b0100},
      {1'b1, 1'b1, 4'b1000, 4'b1000},
      {1'b1, 1'b1, 4'b1111, 4'b1110}
   };

   task automatic chk(input string req, input string what,
                      input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic wr_ccr(input logic [3:0] d);
      ccr_wr = 1'b1;
      ccr_wdata = d;
      @(negedge clk);
      ccr_wr = 1'b0;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      cyc(2);
      // R12 reset state
      chk("R12", "status in reset", {6'd0, stby_status}, 8'h00);
      chk("R12", "cpu clk in reset", {7'd0, cpu_clk_en}, 8'h01);
      chk("R12", "clamp in reset", {7'd0, osc_in_clamp}, 8'h00);
      chk("R12", "sel in reset", {6'd0, ccr_sel}, 8'h00);
      chk("R9", "periph in reset", {4'd0, periph_clk_en}, 8'h0F);
      rst_n = 1'b1;
      cyc(2);

      // Table walk: R1 R2 R3 R9 R5 R7
      for (int v = 0; v < NV; v++) begin
         main_osc_on = VEC[v][8];
         periph_alt_sel = VEC[v][7:4];
         wr_ccr(VEC[v][9] ? 4'b1000 : 4'b0100);
         cyc(1);
         chk("R1", "status entry", {6'd0, stby_status}, VEC[v][9] ? 8'h02 : 8'h01);
         chk("R9", "periph enables", {4'd0, periph_clk_en}, {4'd0, VEC[v][3:0]});
         chk(VEC[v][9] ? "R3" : "R2", "osc enable", {7'd0, main_osc_en}, VEC[v][9] ? 8'h00 : 8'h01);
         chk(VEC[v][9] ? "R3" : "R2", "clamp", {7'd0, osc_in_clamp}, {7'd0, VEC[v][9]});
         chk("R2", "cpu gated", {7'd0, cpu_clk_en}, 8'h00);
         irq_en[1] = 1'b1;
         irq_req[1] = 1'b1;
         cyc(20);
         irq_req[1] = 1'b0;
         chk("R5", "back to run", {6'd0, stby_status}, 8'h00);
         main_osc_on = 1'b1;
         periph_alt_sel = '0;
      end

      // R8 settle window
      wr_ccr(4'b0101);
      cyc(4);
      chk("R8", "still run at window end", {6'd0, stby_status}, 8'h00);
      cyc(1);
      chk("R8", "light standby after window", {6'd0, stby_status}, 8'h01);
      chk("R8", "sel stored", {6'd0, ccr_sel}, 8'h01);
      wr_ccr(4'b0011);
      cyc(1);
      irq_req[1] = 1'b1;
      cyc(1);
      irq_req[1] = 1'b0;
      chk("R6", "cpu clk next edge", {7'd0, cpu_clk_en}, 8'h01);
      chk("R11", "sel retained", {6'd0, ccr_sel}, 8'h01);
      cyc(3);
      chk("R11", "request self-cleared", {6'd0, stby_status}, 8'h00);

      // R4 deep request from subsystem clock
      cpu_on_sub = 1'b1;
      wr_ccr(4'b1001);
      cyc(2);
      chk("R4", "deep ignored status", {6'd0, stby_status}, 8'h00);
      chk("R4", "osc stays on", {7'd0, main_osc_en}, 8'h01);
      cpu_on_sub = 1'b0;
      cyc(3);
      chk("R4", "request discarded", {6'd0, stby_status}, 8'h00);
      cpu_on_sub = 1'b1;
      wr_ccr(4'b0101);
      cyc(1);
      chk("R4", "light from subsystem", {6'd0, stby_status}, 8'h01);
      irq_req[1] = 1'b1;
      cyc(1);
      irq_req[1] = 1'b0;
      cpu_on_sub = 1'b0;
      cyc(1);

      // R1 both bits: deep wins; R10 line 0 filter; R5 disabled line
      wr_ccr(4'b1101);
      cyc(1);
      chk("R1", "deep wins", {6'd0, stby_status}, 8'h02);
      irq_en[0] = 1'b1;
      irq_req[0] = 1'b1;
      irq_req[3] = 1'b1;
      cyc(3);
      chk("R10", "line 0 masked in deep", {6'd0, stby_status}, 8'h02);
      chk("R5", "clamp held", {7'd0, osc_in_clamp}, 8'h01);
      int0_bypass = 1'b1;
      cyc(1);
      chk("R7", "clamp released", {7'd0, osc_in_clamp}, 8'h00);
      chk("R7", "osc restarted", {7'd0, main_osc_en}, 8'h01);
      chk("R7", "status during warm-up", {6'd0, stby_status}, 8'h02);
      irq_req = '0;
      cyc(15);
      chk("R7", "cpu gated at last warm cycle", {7'd0, cpu_clk_en}, 8'h00);
      cyc(1);
      chk("R7", "cpu released", {7'd0, cpu_clk_en}, 8'h01);
      chk("R7", "run after warm-up", {6'd0, stby_status}, 8'h00);

      // R10 line 0 valid in light standby
      int0_bypass = 1'b0;
      wr_ccr(4'b0101);
      cyc(1);
      irq_req[0] = 1'b1;
      cyc(1);
      irq_req[0] = 1'b0;
      chk("R10", "line 0 wakes light", {6'd0, stby_status}, 8'h00);

      // R12 reset from deep standby
      wr_ccr(4'b1001);
      cyc(1);
      rst_n = 1'b0;
      #1;
      chk("R12", "reset leaves deep", {6'd0, stby_status}, 8'h00);
      chk("R12", "reset clamp", {7'd0, osc_in_clamp}, 8'h00);
      chk("R12", "reset sel", {6'd0, ccr_sel}, 8'h00);
      cyc(1);
      rst_n = 1'b1;
      cyc(3);
      chk("R12", "no pending after reset", {6'd0, stby_status}, 8'h00);

      summary();
      $finish;
   end
endmodule